// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (Two-Wire)

This block is a two-wire serial slave that holds the seven 8-bit control registers of a clock generator and presents all of their bits in parallel to the rest of the chip. A system clock that is much faster than the serial clock samples SCL and SDA through two-flop synchronizers. START and STOP conditions are detected from the synchronized lines. SDA is handled open-drain: the block only ever asserts a pull-down enable.

A write opens with the 7-bit slave address and a write direction bit. Two more bytes must follow: a command code and a byte count. Both are acknowledged and their contents are thrown away. Every data byte after them lands in the next register, beginning at register 0 and stepping up by one. Bytes sent past the last register are still acknowledged, but they change nothing. A read with the read direction bit returns the registers from register 0 upward. The register pointer is cleared at every START.

Register 0 carries the frequency and spread controls. Bit 0 tri-states all outputs. Bit 1 turns spread on. Bit 2 and bits 6:4 form the 4-bit software frequency code: bit 2 is its top bit, and bits 6:4 are its lower three bits with bit 6 most significant. Bit 3 picks software over strap selection. Bit 7 picks the larger spread amount. In register 1, bit 7 picks centre spread when 1 and down spread when 0, and a 0 there overrides register 0 bit 7. Bits 3:0 of register 1 enable the four CPU clocks. The other registers hold per-output enables.

Top module: `clkgen_cfg_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal parameter SLV_ADDR (default 7'h69). For any other address it leaves SDA released for the acknowledge bit and ignores the rest of the transfer.
- R2: In a write, the two bytes that follow the address are acknowledged and change no register.
- R3: Write data bytes after those two go to register 0, then 1, 2 and upward, and each is acknowledged. Register k appears on cfg_regs[8k+7:8k].
- R4: Data bytes beyond register 6 are acknowledged and discarded, so registers 0 to 6 keep their values.
- R5: The register pointer returns to register 0 at every START, so each new transfer writes or reads from register 0.
- R6: After synchronous reset the registers hold 0x00, 0xFF, 0x7F, 0xFF, 0x0F, 0x13 and 0x00 for registers 0 to 6.
- R7: A read (address LSB 1) is acknowledged. The block then sends register 0, 1, 2 and upward, MSB first, and returns 0xFF past register 6. It stops driving after the master leaves the acknowledge bit high.
- R8: sda_oe is asserted only for an acknowledge or a zero read-data bit. It changes only while SCL is low, and it is deasserted after a STOP.
- R9: Bytes clocked without a preceding START, such as after a STOP, are not acknowledged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; loads register defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, pad pulls SDA low; otherwise SDA is released |
| cfg_regs | output | NREG*8 | All register bits, register k on bits 8k+7:8k |

## Verification
A pointer that is not cleared at START, or that steps during the two leading bytes, shows up within one transfer as register contents shifted by one or more places on cfg_regs. The sweep over data-byte counts from zero to past the end of the bank catches it that way. A wrong bit counter or a wrong acknowledge state shows on SDA within the same byte: an acknowledge goes missing, or a read byte arrives shifted. Both are compared against a register model held in the bench after every transfer.

// File: rtl/ccfg_pkg.sv
// Package: shared states, phases and register defaults for the
// configuration slave. Assumes a bank of at most eight registers.
package ccfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } ccfg_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } ccfg_phase_e;

    // Power-up value of register i; reserved bits default to 0.
    function automatic logic [7:0] reg_default(input int i);
        case (i)
            1:       return 8'hFF;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h0F;
            5:       return 8'h13;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ccfg_sync.sv
// Multi-stage synchronizer for asynchronous inputs. Assumes the inputs
// are level signals that idle high (bus lines), so reset loads ones.
module ccfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: move the sample one flop further down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[s] <= '1;
            end else if (s == 0) begin
                stg[s] <= d_i;
            end else begin
                stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ccfg_busmon.sv
// Bus monitor: synchronizes SCL and SDA and flags SCL edges and
// START/STOP conditions. Assumes SCL high and low phases last several
// system clocks each.
module ccfg_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] synced;
    logic       scl_q;
    logic       sda_q;

    ccfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (synced)
    );

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Purpose: hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = ~scl_q & scl_s;
    assign scl_fall  = scl_q & ~scl_s;
    assign start_det = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/ccfg_regbank.sv
// Register bank: NREG byte registers with one write port and one read
// port. An index at or above NREG writes nothing and reads 0xFF.
module ccfg_regbank
    import ccfg_pkg::*;
#(
    parameter int NREG = 7,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG);

    logic [7:0] bank [NREG];

    // Purpose: load defaults on reset, else store an in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                bank[i] <= reg_default(i);
            end
        end else if (wr_en && (wr_idx < LAST_IDX)) begin
            bank[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = bank[g];
    end

    assign rd_data = (rd_idx < LAST_IDX) ? bank[rd_idx] : 8'hFF;

    // R2: with no write strobe the register contents hold.
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R4: a write aimed past the last register changes nothing.
    assert_discard_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= LAST_IDX)) |=> $stable(regs_flat));

    // R6: leaving reset, the bank shows the power-up values.
    assert_reset_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank[0] == reg_default(0) && bank[NREG-1] == reg_default(NREG-1)));
endmodule

// File: rtl/clkgen_cfg_i2c.sv
// Top: two-wire slave for the clock generator control registers.
// A write carries address, two ignored bytes, then data for registers
// 0 upward. A read returns registers from 0 upward. Assumes clk runs
// at least eight times faster than SCL, with no clock stretching and
// a single master.
module clkgen_cfg_i2c
    import ccfg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         NREG     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs
);
    localparam int              IDXW     = $clog2(NREG + 1);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG);

    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    ccfg_state_e state;
    ccfg_phase_e phase;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  txbyte;
    logic        rw;
    logic        mnack;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] idx_next;
    logic [7:0]  rd_data;
    logic        wr_en;
    logic        byte_done;

    ccfg_busmon u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ccfg_regbank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (idx),
        .wr_data   (shreg),
        .rd_idx    (idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

    // Purpose: flag the falling SCL edge that closes a received byte.
    assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8)
                       && !start_det && !stop_det;
    // Purpose: strobe a register write once a data-phase byte is complete.
    assign wr_en     = byte_done && (phase == PH_DATA);
    // Purpose: saturating pointer step; it parks at NREG past the bank.
    assign idx_next  = (idx < LAST_IDX) ? idx + 1'b1 : idx;

    // Purpose: protocol sequencer for receive, acknowledge and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            txbyte <= '0;
            rw     <= 1'b0;
            mnack  <= 1'b0;
            idx    <= '0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            idx    <= '0;
            rw     <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (phase == PH_ADDR) begin
                            if (shreg[7:1] == SLV_ADDR) begin
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            state  <= ST_ACK;
                            sda_oe <= 1'b1;
                            if (phase == PH_DATA) begin
                                idx <= idx_next;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (phase == PH_ADDR && rw) begin
                            state  <= ST_TX;
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                            idx    <= idx_next;
                            bitcnt <= '0;
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                            case (phase)
                                PH_ADDR: phase <= PH_CMD;
                                PH_CMD:  phase <= PH_CNT;
                                default: phase <= PH_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            state  <= ST_MACK;
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end else begin
                            txbyte <= {txbyte[6:0], 1'b0};
                            sda_oe <= ~txbyte[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mnack <= sda_s;
                    end else if (scl_fall) begin
                        if (mnack) begin
                            state <= ST_IDLE;
                        end else begin
                            state  <= ST_TX;
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                            idx    <= idx_next;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R8: the data line only moves while the clock line is low.
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R8: an idle slave never pulls the line.
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2: every acknowledge slot pulls the line low.
    assert_ack_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> sda_oe);

    // R5: a START always leaves the pointer at register 0.
    assert_start_clears_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (idx == '0));
endmodule

// File: tb/sim_clkgen_cfg_i2c.sv
module sim_clkgen_cfg_i2c;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int         NREG = 7;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic master_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_regs;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    assign sda_line = master_sda & ~sda_oe;

    clkgen_cfg_i2c #(.SLV_ADDR(ADDR), .NREG(NREG)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic r);
        master_sda = b;
        qw();
        scl = 1'b1;
        qw();
        r = sda_line;
        qw();
        scl = 1'b0;
        qw();
    endtask

    task automatic do_start();
        master_sda = 1'b1;
        qw();
        scl = 1'b1;
        qw();
        master_sda = 1'b0;
        qw();
        scl = 1'b0;
        qw();
    endtask

    task automatic do_stop();
        master_sda = 1'b0;
        qw();
        scl = 1'b1;
        qw();
        master_sda = 1'b1;
        qw();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(d[i], r);
        bit_cycle(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            d[i] = r;
        end
        bit_cycle(~give_ack, r);
    endtask

    task automatic check_all_regs(input string tag);
        for (int k = 0; k < NREG; k++) chk(tag, cfg_regs[k*8 +: 8], model[k]);
    endtask

    task automatic write_burst(input int n);
        logic ack;
        logic [7:0] d;
        do_start();
        send_byte({ADDR, 1'b0}, ack);
        chk("R1 address ack", {7'd0, ack}, 8'd1);
        send_byte(8'(n * 17 + 3), ack);
        chk("R2 command ack", {7'd0, ack}, 8'd1);
        send_byte(8'(n), ack);
        chk("R2 count ack", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            d = 8'((n * 29 + k * 53 + 7) & 255);
            send_byte(d, ack);
            chk(k < NREG ? "R3 data ack" : "R4 overflow ack", {7'd0, ack}, 8'd1);
            if (k < NREG) model[k] = d;
        end
        do_stop();
    endtask

    task automatic read_burst(input int n);
        logic ack;
        logic [7:0] d;
        do_start();
        send_byte({ADDR, 1'b1}, ack);
        chk("R7 read address ack", {7'd0, ack}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k < n - 1);
            chk("R7 read data", d, (k < NREG) ? model[k] : 8'hFF);
        end
        chk("R7 released after master nack", {7'd0, sda_oe}, 8'd0);
        do_stop();
        chk("R8 released after stop", {7'd0, sda_oe}, 8'd0);
    endtask

    initial begin
        logic ack;
        for (int k = 0; k < NREG; k++) model[k] = 8'h00;
        model[1] = 8'hFF; model[2] = 8'h7F; model[3] = 8'hFF;
        model[4] = 8'h0F; model[5] = 8'h13;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all_regs("R6 reset default");
        chk("R8 idle released", {7'd0, sda_oe}, 8'd0);

        // R3 R4: sweep of data-byte counts, from none to past the bank.
        for (int n = 0; n <= NREG + 2; n++) begin
            write_burst(n);
            check_all_regs("R3 register contents");
            if (n % 3 == 0) read_burst(NREG + 2);
        end

        // R5: a short write after a long one starts again at register 0.
        write_burst(2);
        check_all_regs("R5 pointer cleared at start");
        read_burst(3);

        // R1: wrong addresses are not acknowledged and write nothing.
        for (int a = 0; a < 3; a++) begin
            do_start();
            send_byte({ADDR ^ 7'(1 << (a * 3)), 1'b0}, ack);
            chk("R1 wrong address nack", {7'd0, ack}, 8'd0);
            send_byte(8'h00, ack);
            send_byte(8'h00, ack);
            send_byte(8'hA5, ack);
            chk("R1 ignored after nack", {7'd0, ack}, 8'd0);
            do_stop();
            check_all_regs("R1 registers unchanged");
        end

        // R9: bytes without a START after a STOP are ignored.
        master_sda = 1'b1;
        qw();
        scl = 1'b0;
        qw();
        send_byte({ADDR, 1'b0}, ack);
        chk("R9 no ack without start", {7'd0, ack}, 8'd0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'h5A, ack);
        do_stop();
        check_all_regs("R9 registers unchanged");
        read_burst(NREG + 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule